// File: doc/BRIEF.md
# Panel Power Sequencing Controller

This block brings an LCD timing generator's supply rails up and down in a fixed order. It works as a small program sequencer. Each program step is one of four things: a register write on an address/data strobe port, a timed wait, a handoff to an external common-voltage DAC writer, or the end of the program. Three programs exist. The full power-up program runs when the panel is not yet initialised. The short reprogram runs when a power-on request arrives and the panel is already initialised; it writes only the phase and resolution registers. The power-down program first waits out two frames and then removes the rails in reverse order.

At the moment a request is accepted, the block captures four things: the mode select (VGA or QVGA), the stored phase value with its valid flag, and the stored common-voltage value with its valid flag. From these it derives the phase code, the resolution code and the DAC value. Wait lengths are parameters counted in clock cycles, with `CYC_PER_MS` cycles to one millisecond.

The control FSM has four states:
- `S_IDLE` waits for requests.
- `S_RUN` performs the current step.
- `S_WAIT` counts down a delay.
- `S_DACW` waits for the DAC writer's done signal.

Its transitions are:
- IDLE to RUN when a request is accepted.
- RUN to RUN on a write, which also advances the step index.
- RUN to WAIT on a wait step.
- RUN to DACW on a DAC step.
- RUN to IDLE on the end step, which also updates the initialised flag.
- WAIT to RUN when the timer expires.
- DACW to RUN when the DAC writer reports done.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the block is idle: busy, inited, reg_wr and dac_start are all 0.
- R2: A power-on request while not initialised issues 15 writes as (address, data). The first eleven are (6,1F) (3,03) (4,00) (4,04) (3,07) (6,09) (3,17) (4,06) (6,01) (3,1F) (4,07). Then come (6,00), (1,phase), (7,00) and (1→0 is not used) (0,resolution). A DAC handoff sits between the (6,09) and (3,17) writes.
- R3: The strobe after (4,04) follows it by 3·CYC_PER_MS+2 cycles. The strobe after (4,06) follows it by 2·CYC_PER_MS+2 cycles. In power-down, the first strobe comes 34·CYC_PER_MS+1 cycles after busy rises.
- R4: dac_start is a one-cycle pulse, and no register write occurs until dac_done. In power-up, dac_data carries the stored common voltage if it is valid and 125 otherwise. In power-down, dac_data is 0.
- R5: The phase code is 0x13 in QVGA mode. In VGA mode it is {stored[3:0],1} when the stored value is valid and 0x01 when it is not.
- R6: The resolution register receives 0x00 in VGA mode and 0x01 in QVGA mode.
- R7: A power-off request waits out the frame delay and then writes (4,06) (6,08) (3,14). It then hands zero to the DAC and writes (4,04) (3,04) (6,1E) (3,00) (4,00). At the end it clears inited.
- R8: A power-on request while initialised writes only (1,phase) and then (0,resolution), with no DAC handoff.
- R9: Requests that arrive while busy is 1 have no effect.
- R10: When on and off requests arrive together while idle, power-off wins.
- R11: inited becomes 1 at the end of a power-up. It changes only in the cycle in which busy falls.
- R12: reg_wr is asserted only while busy, never together with dac_start, and only to addresses 0, 1, 3, 4, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request, sampled while idle |
| pwr_off_req | input | 1 | Power-off request, sampled while idle |
| mode_vga | input | 1 | 1 selects VGA, 0 selects QVGA |
| phase_stored | input | 8 | Stored phase value; low nibble used |
| phase_valid | input | 1 | Stored phase value is valid |
| com_stored | input | 8 | Stored common-voltage value |
| com_valid | input | 1 | Stored common-voltage value is valid |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register address |
| reg_data | output | 8 | Register write data |
| dac_start | output | 1 | Start pulse to the DAC writer |
| dac_data | output | 8 | Value handed to the DAC writer |
| dac_done | input | 1 | DAC writer has finished |
| busy | output | 1 | A program is running |
| inited | output | 1 | Panel is powered and initialised |

## Verification
The two functions that can land in the same cycle are power-on and power-off acceptance: both requests are sampled on the same idle edge. The bench raises both together while the panel is initialised and judges the outcome by the logged writes. The first strobe must be the (4,06) write of power-down after the full frame delay, and inited must end at 0. The bench also raises both requests in the middle of a running power-up and checks that the write count and the final inited value are exactly those of an undisturbed run.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int IDX_W  = 5;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_RES   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PHASE = 3'd1;
    localparam logic [ADDR_W-1:0] A_PWR0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PWR1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IFC   = 3'd6;
    localparam logic [ADDR_W-1:0] A_POL   = 3'd7;

    typedef enum logic [1:0] {K_WR, K_WAIT, K_DAC, K_END} kind_e;
    typedef enum logic [1:0] {PG_UP, PG_REPROG, PG_DOWN} prog_e;
    typedef enum logic [1:0] {DL_VDD, DL_GVSS, DL_SETTLE, DL_FRAME} dly_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_DACW} fsm_e;

    typedef struct packed {
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        dly_e               dly;
        logic               dac_zero;
    } step_t;

    function automatic step_t st_wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        step_t s;
        s      = '0;
        s.kind = K_WR;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    function automatic step_t st_wait(dly_e d);
        step_t s;
        s      = '0;
        s.kind = K_WAIT;
        s.dly  = d;
        return s;
    endfunction

    function automatic step_t st_dac(logic zero);
        step_t s;
        s          = '0;
        s.kind     = K_DAC;
        s.dac_zero = zero;
        return s;
    endfunction

    function automatic step_t st_end();
        step_t s;
        s      = '0;
        s.kind = K_END;
        return s;
    endfunction

endpackage

// File: rtl/pps_prog.sv
module pps_prog
    import pps_pkg::*;
(
    input  prog_e              prog,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  phase_code,
    input  logic [DATA_W-1:0]  res_code,
    output step_t              step
);

    always_comb begin
        step = st_end();
        unique case (prog)
            PG_UP: begin
                case (idx)
                    5'd0:    step = st_wr(A_IFC,   8'h1F);
                    5'd1:    step = st_wr(A_PWR0,  8'h03);
                    5'd2:    step = st_wr(A_PWR1,  8'h00);
                    5'd3:    step = st_wr(A_PWR1,  8'h04);
                    5'd4:    step = st_wait(DL_VDD);
                    5'd5:    step = st_wr(A_PWR0,  8'h07);
                    5'd6:    step = st_wr(A_IFC,   8'h09);
                    5'd7:    step = st_dac(1'b0);
                    5'd8:    step = st_wr(A_PWR0,  8'h17);
                    5'd9:    step = st_wr(A_PWR1,  8'h06);
                    5'd10:   step = st_wait(DL_GVSS);
                    5'd11:   step = st_wr(A_IFC,   8'h01);
                    5'd12:   step = st_wr(A_PWR0,  8'h1F);
                    5'd13:   step = st_wr(A_PWR1,  8'h07);
                    5'd14:   step = st_wr(A_IFC,   8'h00);
                    5'd15:   step = st_wr(A_PHASE, phase_code);
                    5'd16:   step = st_wr(A_POL,   8'h00);
                    5'd17:   step = st_wr(A_RES,   res_code);
                    5'd18:   step = st_wait(DL_SETTLE);
                    default: step = st_end();
                endcase
            end
            PG_REPROG: begin
                case (idx)
                    5'd0:    step = st_wr(A_PHASE, phase_code);
                    5'd1:    step = st_wr(A_RES,   res_code);
                    default: step = st_end();
                endcase
            end
            PG_DOWN: begin
                case (idx)
                    5'd0:    step = st_wait(DL_FRAME);
                    5'd1:    step = st_wr(A_PWR1,  8'h06);
                    5'd2:    step = st_wr(A_IFC,   8'h08);
                    5'd3:    step = st_wr(A_PWR0,  8'h14);
                    5'd4:    step = st_dac(1'b1);
                    5'd5:    step = st_wr(A_PWR1,  8'h04);
                    5'd6:    step = st_wr(A_PWR0,  8'h04);
                    5'd7:    step = st_wr(A_IFC,   8'h1E);
                    5'd8:    step = st_wr(A_PWR0,  8'h00);
                    5'd9:    step = st_wr(A_PWR1,  8'h00);
                    default: step = st_end();
                endcase
            end
            default: step = st_end();
        endcase
    end

endmodule

// File: rtl/pps_param.sv
module pps_param
    import pps_pkg::*;
#(
    parameter logic [DATA_W-1:0] COM_DEFAULT = 8'd125,
    parameter logic [DATA_W-1:0] PHASE_QVGA  = 8'h13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic               mode_vga,
    input  logic [DATA_W-1:0]  phase_raw,
    input  logic               phase_ok,
    input  logic [DATA_W-1:0]  com_raw,
    input  logic               com_ok,
    output logic [DATA_W-1:0]  phase_code,
    output logic [DATA_W-1:0]  res_code,
    output logic [DATA_W-1:0]  com_code
);

    logic [DATA_W-1:0] phase_d;
    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] com_d;

    always_comb begin
        if (!mode_vga)
            phase_d = PHASE_QVGA;
        else if (phase_ok)
            phase_d = {3'b000, phase_raw[3:0], 1'b1};
        else
            phase_d = 8'h01;
        res_d = mode_vga ? 8'h00 : 8'h01;
        com_d = com_ok ? com_raw : COM_DEFAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_code <= '0;
            res_code   <= '0;
            com_code   <= '0;
        end else if (cap) begin
            phase_code <= phase_d;
            res_code   <= res_d;
            com_code   <= com_d;
        end
    end

endmodule

// File: rtl/pps_timer.sv
module pps_timer
    import pps_pkg::*;
#(
    parameter int CYC_PER_MS = 250000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  dly_e  sel,
    output logic  expired
);

    localparam int LEN_VDD    = 3 * CYC_PER_MS;
    localparam int LEN_GVSS   = 2 * CYC_PER_MS;
    localparam int LEN_SETTLE = 1 * CYC_PER_MS;
    localparam int LEN_FRAME  = 34 * CYC_PER_MS;
    localparam int CNT_W      = $clog2(LEN_FRAME + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;

    always_comb begin
        unique case (sel)
            DL_VDD:    len_m1 = CNT_W'(LEN_VDD - 1);
            DL_GVSS:   len_m1 = CNT_W'(LEN_GVSS - 1);
            DL_SETTLE: len_m1 = CNT_W'(LEN_SETTLE - 1);
            DL_FRAME:  len_m1 = CNT_W'(LEN_FRAME - 1);
            default:   len_m1 = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len_m1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int CYC_PER_MS = 250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_on_req,
    input  logic        pwr_off_req,
    input  logic        mode_vga,
    input  logic [7:0]  phase_stored,
    input  logic        phase_valid,
    input  logic [7:0]  com_stored,
    input  logic        com_valid,
    output logic        reg_wr,
    output logic [2:0]  reg_addr,
    output logic [7:0]  reg_data,
    output logic        dac_start,
    output logic [7:0]  dac_data,
    input  logic        dac_done,
    output logic        busy,
    output logic        inited
);

    fsm_e              state_q, state_d;
    prog_e             prog_q, prog_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              inited_q, inited_d;
    logic              cap;
    logic              tmr_load;
    logic              tmr_expired;
    step_t             step;
    logic [DATA_W-1:0] phase_code, res_code, com_code;

    pps_param u_param (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .mode_vga   (mode_vga),
        .phase_raw  (phase_stored),
        .phase_ok   (phase_valid),
        .com_raw    (com_stored),
        .com_ok     (com_valid),
        .phase_code (phase_code),
        .res_code   (res_code),
        .com_code   (com_code)
    );

    pps_prog u_prog (
        .prog       (prog_q),
        .idx        (idx_q),
        .phase_code (phase_code),
        .res_code   (res_code),
        .step       (step)
    );

    pps_timer #(.CYC_PER_MS(CYC_PER_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .sel     (step.dly),
        .expired (tmr_expired)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        prog_d   = prog_q;
        idx_d    = idx_q;
        inited_d = inited_q;
        cap      = 1'b0;
        tmr_load = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (pwr_off_req) begin
                    prog_d  = PG_DOWN;
                    idx_d   = '0;
                    cap     = 1'b1;
                    state_d = S_RUN;
                end else if (pwr_on_req) begin
                    prog_d  = inited_q ? PG_REPROG : PG_UP;
                    idx_d   = '0;
                    cap     = 1'b1;
                    state_d = S_RUN;
                end
            end
            S_RUN: begin
                unique case (step.kind)
                    K_WR:   idx_d = idx_q + 1'b1;
                    K_WAIT: begin
                        tmr_load = 1'b1;
                        state_d  = S_WAIT;
                    end
                    K_DAC:  state_d = S_DACW;
                    K_END: begin
                        inited_d = (prog_q != PG_DOWN);
                        state_d  = S_IDLE;
                    end
                    default: state_d = S_IDLE;
                endcase
            end
            S_WAIT: begin
                if (tmr_expired) begin
                    idx_d   = idx_q + 1'b1;
                    state_d = S_RUN;
                end
            end
            S_DACW: begin
                if (dac_done) begin
                    idx_d   = idx_q + 1'b1;
                    state_d = S_RUN;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            prog_q   <= PG_UP;
            idx_q    <= '0;
            inited_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            prog_q   <= prog_d;
            idx_q    <= idx_d;
            inited_q <= inited_d;
        end
    end

    // outputs
    always_comb begin
        reg_wr    = (state_q == S_RUN) && (step.kind == K_WR);
        reg_addr  = reg_wr ? step.addr : '0;
        reg_data  = reg_wr ? step.data : '0;
        dac_start = (state_q == S_RUN) && (step.kind == K_DAC);
        dac_data  = step.dac_zero ? '0 : com_code;
        busy      = (state_q != S_IDLE);
        inited    = inited_q;
    end

endmodule

// File: rtl/pps_chk.sv
module pps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       dac_start,
    input logic [7:0] dac_data,
    input logic       dac_done,
    input logic       busy,
    input logic       inited
);

    // R12
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> busy);

    // R12
    wr_dac_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !dac_start);

    // R12
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd6, 3'd7}));

    // R4
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_start |=> !dac_start);

    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_start && !dac_done) |=> $stable(dac_data));

    // R4
    dac_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_start |=> !reg_wr);

    // R11
    inited_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inited) |-> $fell(busy));

endmodule

bind panel_pwr_seq pps_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .dac_start (dac_start),
    .dac_data  (dac_data),
    .dac_done  (dac_done),
    .busy      (busy),
    .inited    (inited)
);

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;

    localparam int CPM = 20;

    // {addr[2:0], data[7:0]}; entries 0..14 power-up, 15..22 power-down
    localparam logic [10:0] TAB [0:22] = '{
        11'h61F, 11'h303, 11'h400, 11'h404, 11'h307, 11'h609, 11'h317, 11'h406,
        11'h601, 11'h31F, 11'h407, 11'h600, 11'h100, 11'h700, 11'h000,
        11'h406, 11'h608, 11'h314, 11'h404, 11'h304, 11'h61E, 11'h300, 11'h400
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       pwr_on_req, pwr_off_req, mode_vga, phase_valid, com_valid;
    logic [7:0] phase_stored, com_stored;
    logic       reg_wr, dac_start, dac_done, busy, inited;
    logic [2:0] reg_addr;
    logic [7:0] reg_data, dac_data;

    panel_pwr_seq #(.CYC_PER_MS(CPM)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_on_req   (pwr_on_req),
        .pwr_off_req  (pwr_off_req),
        .mode_vga     (mode_vga),
        .phase_stored (phase_stored),
        .phase_valid  (phase_valid),
        .com_stored   (com_stored),
        .com_valid    (com_valid),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_data     (reg_data),
        .dac_start    (dac_start),
        .dac_data     (dac_data),
        .dac_done     (dac_done),
        .busy         (busy),
        .inited       (inited)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write logger
    int         cyc = 0;
    int         nlog = 0;
    int         rise_cyc = 0;
    logic       prev_busy = 1'b0;
    logic [2:0] la [256];
    logic [7:0] ld [256];
    int         lc [256];

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (reg_wr === 1'b1 && nlog < 256) begin
                la[nlog] = reg_addr;
                ld[nlog] = reg_data;
                lc[nlog] = cyc;
                nlog++;
            end
            if (busy === 1'b1 && !prev_busy) rise_cyc = cyc;
            prev_busy = (busy === 1'b1);
        end
    end

    // DAC writer model
    int         ndac = 0;
    logic [7:0] dval [16];
    int         dac_wr_during = 0;
    initial begin
        dac_done = 1'b0;
        forever begin
            @(negedge clk);
            if (dac_start === 1'b1) begin
                int start_n;
                if (ndac < 16) dval[ndac] = dac_data;
                ndac++;
                start_n = nlog;
                repeat (6) @(negedge clk);
                dac_wr_during += nlog - start_n;
                dac_done = 1'b1;
                @(negedge clk);
                dac_done = 1'b0;
            end
        end
    end

    task automatic do_req(input logic on, input logic off, input logic vga,
                          input logic [7:0] ph, input logic phok,
                          input logic [7:0] cv, input logic cvok);
        @(negedge clk);
        pwr_on_req   = on;
        pwr_off_req  = off;
        mode_vga     = vga;
        phase_stored = ph;
        phase_valid  = phok;
        com_stored   = cv;
        com_valid    = cvok;
        @(negedge clk);
        pwr_on_req  = 1'b0;
        pwr_off_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_up(input int base, input int ph, input int res,
                            input int dac_idx, input int dac_exp);
        chk("R2 power-up write count", nlog - base, 15);
        for (int i = 0; i < 15; i++) begin
            int ea, ed;
            ea = int'(TAB[i][10:8]);
            ed = (i == 12) ? ph : (i == 14) ? res : int'(TAB[i][7:0]);
            chk($sformatf("R2 up addr #%0d", i), int'(la[base+i]), ea);
            if (i == 12)      chk("R5 phase code", int'(ld[base+i]), ed);
            else if (i == 14) chk("R6 resolution code", int'(ld[base+i]), ed);
            else chk($sformatf("R2 up data #%0d", i), int'(ld[base+i]), ed);
        end
        chk("R3 VDD wait spacing", lc[base+4] - lc[base+3], 3*CPM + 2);
        chk("R3 GVSS wait spacing", lc[base+8] - lc[base+7], 2*CPM + 2);
        chk("R4 up DAC value", int'(dval[dac_idx]), dac_exp);
        chk("R4 DAC count", ndac, dac_idx + 1);
        chk("R11 inited after power-up", int'(inited), 1);
    endtask

    task automatic check_down(input int base, input int dac_idx);
        chk("R7 power-down write count", nlog - base, 8);
        for (int i = 0; i < 8; i++) begin
            chk($sformatf("R7 down addr #%0d", i), int'(la[base+i]), int'(TAB[15+i][10:8]));
            chk($sformatf("R7 down data #%0d", i), int'(ld[base+i]), int'(TAB[15+i][7:0]));
        end
        chk("R3 frame wait", lc[base] - rise_cyc, 34*CPM + 1);
        chk("R4 down DAC value", int'(dval[dac_idx]), 0);
        chk("R7 inited cleared", int'(inited), 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int base, d0;
        rst_n = 1'b0;
        pwr_on_req = 0; pwr_off_req = 0; mode_vga = 0;
        phase_stored = 0; phase_valid = 0; com_stored = 0; com_valid = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 inited", int'(inited), 0);
        chk("R1 reg_wr", int'(reg_wr), 0);
        chk("R1 dac_start", int'(dac_start), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // A: full power-up, QVGA, invalid common voltage
        base = nlog;
        do_req(1, 0, 0, 8'h05, 1, 8'h33, 0);
        wait_idle();
        check_up(base, 8'h13, 8'h01, 0, 125);
        chk("R4 no write during DAC", dac_wr_during, 0);

        // B: repeat power-on, VGA, valid phase
        base = nlog; d0 = ndac;
        do_req(1, 0, 1, 8'h5A, 1, 8'h00, 0);
        wait_idle();
        chk("R8 reprogram count", nlog - base, 2);
        chk("R8 phase addr", int'(la[base]), 1);
        chk("R5 VGA valid phase", int'(ld[base]), 8'h15);
        chk("R8 res addr", int'(la[base+1]), 0);
        chk("R6 VGA resolution", int'(ld[base+1]), 8'h00);
        chk("R8 no DAC handoff", ndac, d0);

        // C: repeat power-on, VGA, invalid phase
        base = nlog;
        do_req(1, 0, 1, 8'hFF, 0, 8'h00, 0);
        wait_idle();
        chk("R5 VGA invalid phase", int'(ld[base]), 8'h01);
        chk("R6 VGA resolution again", int'(ld[base+1]), 8'h00);

        // D: power-down
        base = nlog;
        do_req(0, 1, 0, 8'h00, 0, 8'h00, 0);
        wait_idle();
        check_down(base, 1);

        // E: power-up VGA, valid values, requests while busy are ignored (R9)
        base = nlog;
        do_req(1, 0, 1, 8'h07, 1, 8'h40, 1);
        repeat (5) @(negedge clk);
        pwr_on_req = 1; pwr_off_req = 1; mode_vga = 0;
        @(negedge clk);
        pwr_on_req = 0; pwr_off_req = 0;
        wait_idle();
        check_up(base, 8'h0F, 8'h00, 2, 8'h40);
        repeat (3) @(negedge clk);
        chk("R9 busy request ignored", int'(busy), 0);
        chk("R9 no extra writes", nlog - base, 15);

        // F: simultaneous on and off while idle: off wins (R10)
        base = nlog;
        do_req(1, 1, 1, 8'h03, 1, 8'h10, 1);
        wait_idle();
        chk("R10 off wins first addr", int'(la[base]), 4);
        chk("R10 off wins first data", int'(ld[base]), 8'h06);
        check_down(base, 3);

        // G: power-up again after power-down runs the full program
        base = nlog;
        do_req(1, 0, 0, 8'h00, 0, 8'h7E, 1);
        wait_idle();
        check_up(base, 8'h13, 8'h01, 4, 8'h7E);
        chk("R4 no write during any DAC", dac_wr_during, 0);

        summary();
        $finish;
    end

endmodule